// File: doc/BRIEF.md
# Pre-Bias Startup Low-Side Pulse Stepper

This block sits between a PWM modulator and the low-side gate driver of a synchronous buck stage. When the converter starts into an output that is already charged, conducting through the low-side switch at full complementary duty would pull current back out of the output. The stepper therefore keeps the low-side switch off while the converter runs asynchronously. The wait ends at the first high-side gate request. From then on it lets the low-side on-time grow in fractional steps of the switching period until ordinary synchronous operation is reached.

Every step allows the low-side drive to stay on for `step × PERIOD_CYCLES / STEPS` clock cycles of each low-side pulse. The count starts at the pulse's turn-on. A step lasts a fixed number of switching periods, which are counted on the start-of-period strobe. After the last step the nominal low-side request passes through unchanged and an end-of-pre-bias flag is raised. Dropping the startup enable returns the block to its waiting state.

Top module: `pbStepper`

## Requirements
- R1: After reset, `stepIdx` is 0, `pbDone` is 0 and `lsDrive` is 0.
- R2: While waiting (enabled, with no high-side request yet sampled since enable), `lsDrive` stays 0 and `stepIdx` stays 0, whatever `lsReq` does.
- R3: The first clock edge that samples `hsReq`=1 with `startEn`=1 in the waiting state sets `stepIdx` to 1. A `periodStart` sampled on that same edge is not counted.
- R4: While `stepIdx`=k (1..STEPS) and `pbDone`=0, `lsDrive` equals `lsReq` AND (n < k·PERIOD_CYCLES/STEPS). Here n is the number of preceding edges at which `lsReq` was sampled continuously high, so n is 0 in the first cycle of a low-side pulse.
- R5: `stepIdx` advances by exactly 1 on the edge that samples the PULSES_PER_STEP-th `periodStart` since the current step began. It changes at no other edge except when it returns to 0.
- R6: The edge that completes step STEPS sets `pbDone`=1 and holds `stepIdx`=STEPS. From then on, `lsDrive` equals `lsReq`.
- R7: While `startEn`=0, `lsDrive` is 0 in the same cycle. From the next edge, `stepIdx`=0 and `pbDone`=0, and stepping restarts only after a new high-side request.
- R8: `lsDrive` is never 1 while `lsReq` is 0.
- R9: `hsReq` sampled while `startEn`=0 does not start stepping: `stepIdx` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEn | input | 1 | Startup enable; low holds the block in the waiting state |
| periodStart | input | 1 | One-cycle strobe at the start of each switching period |
| hsReq | input | 1 | High-side gate request from the PWM |
| lsReq | input | 1 | Nominal complementary low-side request |
| lsDrive | output | 1 | Gated low-side drive |
| stepIdx | output | $clog2(STEPS+1) | Current step; 0 while waiting, STEPS when finished |
| pbDone | output | 1 | End of the pre-bias phase |

## Verification
On every cycle, the checker confirms the following:
- no low-side drive occurs while waiting, while disabled or without a request;
- pass-through holds once finished;
- the step index moves only by single increments on a period strobe, or back to zero;
- no drive run exceeds the current step's window.

Only the bench scenarios show the absolute timing: that a step lasts exactly the configured number of period strobes, that the window length in each period matches the step for both wide and narrow low-side pulses, and that the hand-off happens on the right period. Restart after a mid-run or post-completion disable, and a high-side request ignored while disabled, also depend on those scenarios.

// File: rtl/pbStepPkg.sv
package pbStepPkg;
  typedef enum logic [1:0] {
    PB_WAIT = 2'd0,
    PB_STEP = 2'd1,
    PB_DONE = 2'd2
  } pbState_e;

  typedef struct packed {
    logic holdOff;
    logic passThru;
  } pbStrobe_t;
endpackage

// File: rtl/pbStepCtrl.sv
module pbStepCtrl
  import pbStepPkg::*;
#(
  parameter int STEPS = 8,
  parameter int PULSES_PER_STEP = 16,
  localparam int STEP_W = $clog2(STEPS + 1),
  localparam int PC_W = $clog2(PULSES_PER_STEP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEn,
  input  logic              periodStart,
  input  logic              hsReq,
  output pbStrobe_t         strobe,
  output logic [STEP_W-1:0] stepIdx,
  output logic              pbDone
);
  localparam logic [PC_W-1:0] LAST_PULSE = PC_W'(PULSES_PER_STEP - 1);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(STEPS);

  pbState_e state;
  logic [STEP_W-1:0] step;
  logic [PC_W-1:0] pulseCnt;

  always_ff @(posedge clk) begin
    if (!rstN || !startEn) begin
      state    <= PB_WAIT;
      step     <= '0;
      pulseCnt <= '0;
    end else begin
      case (state)
        PB_WAIT: begin
          if (hsReq) begin
            state    <= PB_STEP;
            step     <= STEP_W'(1);
            pulseCnt <= '0;
          end
        end
        PB_STEP: begin
          if (periodStart) begin
            if (pulseCnt == LAST_PULSE) begin
              pulseCnt <= '0;
              if (step == LAST_STEP) state <= PB_DONE;
              else                   step  <= step + STEP_W'(1);
            end else begin
              pulseCnt <= pulseCnt + PC_W'(1);
            end
          end
        end
        default: state <= PB_DONE;
      endcase
    end
  end

  always_comb begin
    strobe.holdOff  = !startEn || (state == PB_WAIT);
    strobe.passThru = startEn && (state == PB_DONE);
  end

  assign stepIdx = step;
  assign pbDone  = (state == PB_DONE);
endmodule

// File: rtl/pbStepDatapath.sv
module pbStepDatapath
  import pbStepPkg::*;
#(
  parameter int PERIOD_CYCLES = 64,
  parameter int STEPS = 8,
  localparam int STEP_W = $clog2(STEPS + 1),
  localparam int CNT_W = $clog2(PERIOD_CYCLES + 1),
  localparam int WIN_W = STEP_W + CNT_W,
  localparam int SLICE = PERIOD_CYCLES / STEPS
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbStrobe_t         strobe,
  input  logic [STEP_W-1:0] stepIdx,
  input  logic              lsReq,
  output logic              lsDrive
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(PERIOD_CYCLES);

  logic [CNT_W-1:0] onCnt;
  logic [WIN_W-1:0] winLen;
  logic inWindow;

  always_ff @(posedge clk) begin
    if (!rstN || !lsReq)       onCnt <= '0;
    else if (onCnt != CNT_MAX) onCnt <= onCnt + CNT_W'(1);
  end

  always_comb begin
    winLen   = WIN_W'(stepIdx) * WIN_W'(SLICE);
    inWindow = WIN_W'(onCnt) < winLen;
    lsDrive  = lsReq && !strobe.holdOff && (strobe.passThru || inWindow);
  end
endmodule

// File: rtl/pbStepper.sv
module pbStepper
  import pbStepPkg::*;
#(
  parameter int PERIOD_CYCLES = 64,
  parameter int STEPS = 8,
  parameter int PULSES_PER_STEP = 16,
  localparam int STEP_W = $clog2(STEPS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEn,
  input  logic              periodStart,
  input  logic              hsReq,
  input  logic              lsReq,
  output logic              lsDrive,
  output logic [STEP_W-1:0] stepIdx,
  output logic              pbDone
);
  pbStrobe_t strobe;

  pbStepCtrl #(.STEPS(STEPS), .PULSES_PER_STEP(PULSES_PER_STEP)) ctrl (
    .clk(clk), .rstN(rstN), .startEn(startEn), .periodStart(periodStart),
    .hsReq(hsReq), .strobe(strobe), .stepIdx(stepIdx), .pbDone(pbDone)
  );

  pbStepDatapath #(.PERIOD_CYCLES(PERIOD_CYCLES), .STEPS(STEPS)) dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIdx(stepIdx),
    .lsReq(lsReq), .lsDrive(lsDrive)
  );
endmodule

// File: rtl/pbStepperChecker.sv
module pbStepperChecker #(
  parameter int STEPS = 8,
  parameter int SLICE = 8,
  localparam int STEP_W = $clog2(STEPS + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              startEn,
  input logic              periodStart,
  input logic              lsReq,
  input logic              lsDrive,
  input logic [STEP_W-1:0] stepIdx,
  input logic              pbDone
);
  logic [15:0] lsRun;

  always_ff @(posedge clk) begin
    if (!rstN || !lsDrive)    lsRun <= '0;
    else if (lsRun != 16'hFFFF) lsRun <= lsRun + 16'd1;
  end

  AST_HOLD_OFF_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx == '0) |-> !lsDrive); // R2

  AST_DRIVE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    lsDrive |-> lsReq); // R8

  AST_DISABLE_GATES: assert property (@(posedge clk) disable iff (!rstN)
    !startEn |-> !lsDrive); // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !startEn |=> (stepIdx == '0 && !pbDone)); // R7

  AST_DONE_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (pbDone && startEn) |-> (lsDrive == lsReq)); // R6

  AST_DONE_AT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    pbDone |-> (32'(stepIdx) == STEPS)); // R6

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx != $past(stepIdx)) |-> (stepIdx == '0 || stepIdx == $past(stepIdx) + 1'b1)); // R5

  AST_STEP_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (stepIdx != $past(stepIdx) && stepIdx != '0 && $past(stepIdx) != '0) |-> $past(periodStart)); // R5

  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (lsDrive && !pbDone) |-> (32'(lsRun) < 32'(stepIdx) * SLICE)); // R4
endmodule

bind pbStepper pbStepperChecker #(.STEPS(STEPS), .SLICE(PERIOD_CYCLES / STEPS)) chk (
  .clk(clk), .rstN(rstN), .startEn(startEn), .periodStart(periodStart),
  .lsReq(lsReq), .lsDrive(lsDrive), .stepIdx(stepIdx), .pbDone(pbDone)
);

// File: tb/pbStepper_test.sv
module pbStepper_test;
  localparam int CLK_PERIOD = 10;
  localparam int P = 16;
  localparam int STEPS = 8;
  localparam int PULSES = 16;
  localparam int SLICE = P / STEPS;
  localparam int STEP_W = $clog2(STEPS + 1);

  logic clk = 1'b0;
  logic rstN, startEn, periodStart, hsReq, lsReq;
  logic lsDrive, pbDone;
  logic [STEP_W-1:0] stepIdx;
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pbStepper #(.PERIOD_CYCLES(P), .STEPS(STEPS), .PULSES_PER_STEP(PULSES)) uut (
    .clk(clk), .rstN(rstN), .startEn(startEn), .periodStart(periodStart),
    .hsReq(hsReq), .lsReq(lsReq), .lsDrive(lsDrive), .stepIdx(stepIdx), .pbDone(pbDone)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int stepFor(int p);
    if (p >= STEPS * PULSES) return STEPS;
    return p / PULSES + 1;
  endfunction

  function automatic int doneFor(int p);
    return (p >= STEPS * PULSES) ? 1 : 0;
  endfunction

  // Waiting periods: hsReq low, lsReq held high (R2)
  task automatic waitPeriods(int n);
    for (int i = 0; i < n * P; i++) begin
      periodStart = (i % P == 0); hsReq = 0; lsReq = 1;
      #1;
      check("R2 lsDrive", lsDrive, 0);
      check("R2 stepIdx", stepIdx, 0);
      @(negedge clk);
    end
  endtask

  // Startup run with hsW-cycle high-side pulses; period 0 holds the first hsReq (R3-R6)
  task automatic runStartup(int hsW, int nPer);
    for (int p = 0; p < nPer; p++) begin
      for (int c = 0; c < P; c++) begin
        int expStep, expDone, expLs;
        periodStart = (c == 0); hsReq = (c < hsW); lsReq = (c >= hsW);
        #1;
        if (c == 0) begin
          expStep = (p == 0) ? 0 : stepFor(p - 1);
          expDone = (p == 0) ? 0 : doneFor(p - 1);
          expLs = 0;
        end else begin
          expStep = stepFor(p);
          expDone = doneFor(p);
          if (c < hsW) expLs = 0;
          else if (expDone == 1) expLs = 1;
          else expLs = ((c - hsW) < expStep * SLICE) ? 1 : 0;
        end
        if (p == 0 && c == 1) check("R3 first step", stepIdx, 1);
        check("R5 stepIdx", stepIdx, expStep);
        check("R6 pbDone", pbDone, expDone);
        check(expDone == 1 ? "R6 pass-through" : "R4 window", lsDrive, expLs);
        if (!lsReq) check("R8 no drive w/o request", lsDrive, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic disableAndRestart();
    startEn = 0; periodStart = 0; hsReq = 0; lsReq = 1;
    #1;
    check("R7 drive gated", lsDrive, 0);
    @(negedge clk);
    #1;
    check("R7 stepIdx cleared", stepIdx, 0);
    check("R7 pbDone cleared", pbDone, 0);
    check("R7 drive gated", lsDrive, 0);
    @(negedge clk);
    hsReq = 1; lsReq = 0; periodStart = 1;
    @(negedge clk);
    #1;
    check("R9 hsReq ignored while disabled", stepIdx, 0);
    @(negedge clk);
    startEn = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 0; startEn = 0; periodStart = 0; hsReq = 0; lsReq = 0;
    repeat (3) @(negedge clk);
    lsReq = 1; startEn = 1;
    #1;
    check("R1 stepIdx", stepIdx, 0);
    check("R1 pbDone", pbDone, 0);
    check("R1 lsDrive", lsDrive, 0);
    @(negedge clk);
    rstN = 1;
    #1;
    check("R1 lsDrive after release", lsDrive, 0);
    @(negedge clk);

    waitPeriods(3);
    runStartup(4, STEPS * PULSES + 3);

    disableAndRestart();
    waitPeriods(2);
    runStartup(13, 40);

    disableAndRestart();
    waitPeriods(1);
    runStartup(1, STEPS * PULSES + 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule